// File: doc/BRIEF.md
# Two-wire serial clock phase generator

This block produces the serial clock for a two-wire bus master. It runs from the peripheral clock and counts the low and the high part of each bus clock period separately. A single configuration word gives a power-of-two prescale exponent and two 8-bit divisors, one for each phase. Every phase lasts `divisor * 2^exponent + OFFSET` peripheral clocks. `OFFSET` is a fixed build-time constant. When the two divisors are equal, the bus clock frequency is `F_periph / (2 * (div * 2^exp + OFFSET))`. With the usual settings this gives 100 kHz for standard mode and up to 400 kHz for fast mode.

Along with the line level, the block emits one-cycle pulses on each falling and rising transition. A transfer engine uses these pulses to shift data. The engine can also stretch the clock: while its hold request is high, the low phase is not allowed to end. A configuration word can be written at any time. It is stored in a shadow register and is adopted as a pair (low and high length together) only when the next low phase begins. A phase that is already running therefore always completes with its old length. When the block is disabled, the line is released high and the counter is cleared.

Top module: `tw_scl_gen`

## Requirements
- R1: After reset, with the block disabled, `scl_o` is 1 and both `rise_tick` and `fall_tick` are 0.
- R2: While `enable` is sampled low, `scl_o` is 1 from the next cycle on and no tick pulses. When `enable` is sampled high from the disabled state, `scl_o` falls in the next cycle and a full low phase starts.
- R3: The low phase lasts `ldiv * 2^e + OFFSET` clock cycles, where `ldiv` is the low divisor and `e` is the effective exponent.
- R4: The high phase lasts `hdiv * 2^e + OFFSET` clock cycles, where `hdiv` is the high divisor.
- R5: In the configuration word, bits [7:0] hold the low divisor, bits [15:8] hold the high divisor, and bits [16 +: EXP_FIELD_W] hold the exponent.
- R6: An exponent field greater than `MAX_EXP` behaves exactly as `MAX_EXP`. With the defaults, exponents 6 and 7 act as 5.
- R7: A word written with `cfg_wr` is used from the start of the next low phase, for both that low phase and the high phase after it. The phase in progress and its paired high phase keep the old lengths.
- R8: While `stretch` is 1, the low phase does not end. Once `stretch` is sampled 0 with the low count expired, `scl_o` rises in the next cycle and a full-length high phase follows. `stretch` has no effect on a high phase.
- R9: `fall_tick` is 1 for exactly the first cycle in which `scl_o` is 0, and `rise_tick` is 1 for exactly the first cycle in which `scl_o` is 1. The two are never high together.
- R10: A divisor of 0 gives a phase of exactly `OFFSET` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the clock generator; low releases the line and clears the counter |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_data | input | 16+EXP_FIELD_W | Configuration word: exponent, high divisor, low divisor |
| stretch | input | 1 | Hold request from the transfer engine; keeps the line low |
| scl_o | output | 1 | Serial clock level (1 = released) |
| fall_tick | output | 1 | One-cycle pulse in the first low cycle |
| rise_tick | output | 1 | One-cycle pulse in the first high cycle |

## Verification
Phase lengths are measured in clock cycles for several settings. Unequal divisors separate the low field from the high field. A zero divisor leaves the offset alone. A mid-range exponent confirms the shift. The largest legal setting exercises the full counter width. An exponent above the cap must give the same lengths as the cap itself. A word written during a low phase must leave that period untouched and change only the following period. Holding `stretch` in the low phase and then in the high phase shows that it extends only the low phase. Disabling the block mid-phase and re-enabling it must release the line and restart with a full low phase.

// File: rtl/tw_clk_pkg.sv
package tw_clk_pkg;
  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_LOW = 2'd1, PH_HIGH = 2'd2} phase_t;
endpackage

// File: rtl/tw_wave_decode.sv
module tw_wave_decode #(
  parameter int DIV_W       = 8,
  parameter int EXP_FIELD_W = 3,
  parameter int MAX_EXP     = 5,
  parameter int OFFSET      = 4,
  parameter int CNT_W       = DIV_W + MAX_EXP + 1,
  localparam int WORD_W     = 2 * DIV_W + EXP_FIELD_W
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [CNT_W-1:0]  low_len_o,
  output logic [CNT_W-1:0]  high_len_o
);
  localparam logic [EXP_FIELD_W-1:0] EXP_CAP = EXP_FIELD_W'(MAX_EXP);

  logic [EXP_FIELD_W-1:0] exp_raw, exp_eff;
  logic [CNT_W-1:0]       len [2];

  assign exp_raw = word_i[2*DIV_W +: EXP_FIELD_W];
  assign exp_eff = (exp_raw > EXP_CAP) ? EXP_CAP : exp_raw;

  // index 0: low divisor, index 1: high divisor
  for (genvar g = 0; g < 2; g++) begin : g_phase
    logic [DIV_W-1:0] div;
    assign div    = word_i[g*DIV_W +: DIV_W];
    assign len[g] = (CNT_W'(div) << exp_eff) + CNT_W'(OFFSET);
  end

  assign low_len_o  = len[0];
  assign high_len_o = len[1];

  always_comb begin
    a_r6_exp_capped: assert (exp_eff <= EXP_CAP);
    a_r10_min_len: assert (low_len_o >= CNT_W'(OFFSET) && high_len_o >= CNT_W'(OFFSET));
  end
endmodule

// File: rtl/tw_phase_ctr.sv
module tw_phase_ctr #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_len,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr)            cnt_q <= '0;
    else if (load)           cnt_q <= load_len - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R3 / R4: a running phase steps down by one each cycle
  a_r3_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r2_cleared_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> expired);
endmodule

// File: rtl/tw_scl_gen.sv
module tw_scl_gen #(
  parameter int DIV_W       = 8,
  parameter int EXP_FIELD_W = 3,
  parameter int MAX_EXP     = 5,
  parameter int OFFSET      = 4,
  parameter int RESET_WORD  = 32'h0000_0404,
  localparam int WORD_W     = 2 * DIV_W + EXP_FIELD_W,
  localparam int CNT_W      = DIV_W + MAX_EXP + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_wr,
  input  logic [WORD_W-1:0] cfg_data,
  input  logic              stretch,
  output logic              scl_o,
  output logic              fall_tick,
  output logic              rise_tick
);
  import tw_clk_pkg::*;

  logic [WORD_W-1:0] shadow_q;
  logic [CNT_W-1:0]  low_len_new, high_len_new, high_len_q;
  phase_t            phase_q;
  logic              expired, start_low, end_low, ctr_load;
  logic [CNT_W-1:0]  ctr_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shadow_q <= WORD_W'(RESET_WORD);
    else if (cfg_wr) shadow_q <= cfg_data;
  end

  tw_wave_decode #(
    .DIV_W(DIV_W), .EXP_FIELD_W(EXP_FIELD_W), .MAX_EXP(MAX_EXP),
    .OFFSET(OFFSET), .CNT_W(CNT_W)
  ) u_decode (
    .word_i(shadow_q), .low_len_o(low_len_new), .high_len_o(high_len_new)
  );

  assign start_low = enable && (phase_q == PH_IDLE || (phase_q == PH_HIGH && expired));
  assign end_low   = enable && phase_q == PH_LOW && expired && !stretch;
  assign ctr_load  = start_low || end_low;
  assign ctr_len   = start_low ? low_len_new : high_len_q;

  tw_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(!enable), .load(ctr_load),
    .load_len(ctr_len), .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      scl_o      <= 1'b1;
      fall_tick  <= 1'b0;
      rise_tick  <= 1'b0;
      high_len_q <= '0;
    end else if (!enable) begin
      phase_q   <= PH_IDLE;
      scl_o     <= 1'b1;
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
    end else if (start_low) begin
      phase_q    <= PH_LOW;
      scl_o      <= 1'b0;
      fall_tick  <= 1'b1;
      rise_tick  <= 1'b0;
      high_len_q <= high_len_new;
    end else if (end_low) begin
      phase_q   <= PH_HIGH;
      scl_o     <= 1'b1;
      fall_tick <= 1'b0;
      rise_tick <= 1'b1;
    end else begin
      fall_tick <= 1'b0;
      rise_tick <= 1'b0;
    end
  end

  a_r2_released_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_o && !fall_tick && !rise_tick));
  a_r8_stretch_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && stretch && phase_q == PH_LOW) |=> !scl_o);
  a_r9_fall_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> (!scl_o && $past(scl_o)));
  a_r9_rise_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> (scl_o && !$past(scl_o)));
  a_r9_edges_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o != $past(scl_o)) |-> (rise_tick || fall_tick || !$past(enable)));
endmodule

// File: tb/tb_tw_scl_gen.sv
module tb_tw_scl_gen;
  localparam int EXP_FIELD_W = 3;
  localparam int WORD_W = 16 + EXP_FIELD_W;
  localparam int OFFSET = 4;
  localparam int MAXC = 20000;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, cfg_wr = 1'b0, stretch = 1'b0;
  logic [WORD_W-1:0] cfg_data = '0;
  logic scl_o, fall_tick, rise_tick;
  int n_chk = 0, n_fail = 0;

  tw_scl_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .stretch(stretch), .scl_o(scl_o), .fall_tick(fall_tick), .rise_tick(rise_tick)
  );

  always #10 clk = ~clk;

  function automatic logic [WORD_W-1:0] mk(int e, int h, int l);
    return {e[EXP_FIELD_W-1:0], h[7:0], l[7:0]};
  endfunction

  task automatic chk(string req, int act, int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic write_cfg(logic [WORD_W-1:0] w);
    @(negedge clk); cfg_wr = 1'b1; cfg_data = w;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic sync_fall();
    int n = 0;
    do begin @(negedge clk); n++; end while (!fall_tick && n < 3*MAXC);
  endtask

  // starts at a negedge showing fall_tick, ends at the next such negedge
  task automatic measure_pair(output int lo, output int hi);
    lo = 0; hi = 0;
    while (scl_o == 1'b0 && lo < MAXC) begin lo++; @(negedge clk); end
    chk("R9 rise_tick", int'(rise_tick), 1);
    while (scl_o == 1'b1 && hi < MAXC) begin hi++; @(negedge clk); end
    chk("R9 fall_tick", int'(fall_tick), 1);
  endtask

  task automatic expect_pair(string req, logic [WORD_W-1:0] w, int elo, int ehi);
    int lo, hi;
    write_cfg(w);
    sync_fall();
    measure_pair(lo, hi);
    chk({req, " low"}, lo, elo);
    chk({req, " high"}, hi, ehi);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1 scl", int'(scl_o), 1);
      chk("R1 ticks", int'(fall_tick | rise_tick), 0);
    end
  endtask

  task automatic t_enable();
    int lo, hi;
    @(negedge clk); enable = 1'b1;
    @(negedge clk);
    chk("R2 start fall", int'(fall_tick), 1);
    chk("R2 start low", int'(scl_o), 0);
    measure_pair(lo, hi);
    chk("R3 default low", lo, 4 + OFFSET);
    chk("R4 default high", hi, 4 + OFFSET);
  endtask

  task automatic t_defer();
    int lo, hi;
    write_cfg(mk(1, 2, 3));
    sync_fall();
    fork
      begin cfg_wr = 1'b1; cfg_data = mk(0, 1, 1); @(negedge clk); cfg_wr = 1'b0; end
    join_none
    measure_pair(lo, hi);
    chk("R7 old low kept", lo, 10);
    chk("R7 old high kept", hi, 8);
    measure_pair(lo, hi);
    chk("R7 new low", lo, 5);
    chk("R7 new high", hi, 5);
  endtask

  task automatic t_stretch_low();
    int hi = 0, bad = 0;
    write_cfg(mk(0, 3, 2));
    sync_fall();
    stretch = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (scl_o !== 1'b0 || rise_tick) bad++;
    end
    chk("R8 held low", bad, 0);
    stretch = 1'b0;
    @(negedge clk);
    chk("R8 release rise", int'(rise_tick & scl_o), 1);
    while (scl_o == 1'b1 && hi < MAXC) begin hi++; @(negedge clk); end
    chk("R8 full high after release", hi, 3 + OFFSET);
  endtask

  task automatic t_stretch_high();
    int hi = 0;
    sync_fall();
    while (!rise_tick) @(negedge clk);
    stretch = 1'b1;
    while (scl_o == 1'b1 && hi < MAXC) begin hi++; @(negedge clk); end
    chk("R8 high unaffected", hi, 3 + OFFSET);
    stretch = 1'b0;
  endtask

  task automatic t_disable();
    int lo, hi, bad = 0;
    sync_fall();
    repeat (2) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      if (scl_o !== 1'b1 || fall_tick || rise_tick) bad++;
      @(negedge clk);
    end
    chk("R2 released", bad, 0);
    enable = 1'b1;
    @(negedge clk);
    chk("R2 restart fall", int'(fall_tick & ~scl_o), 1);
    measure_pair(lo, hi);
    chk("R2 full low on restart", lo, 2 + OFFSET);
    chk("R2 full high on restart", hi, 3 + OFFSET);
  endtask

  initial begin
    #(20 * 180000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    expect_pair("R5 fields", mk(2, 9, 5), 24, 40);
    expect_pair("R10 zero divisors", mk(3, 0, 0), OFFSET, OFFSET);
    expect_pair("R6 exp at cap", mk(5, 2, 1), 36, 68);
    expect_pair("R6 exp saturated", mk(7, 2, 1), 36, 68);
    expect_pair("R3 R4 largest", mk(5, 255, 255), 8164, 8164);
    t_defer();
    t_stretch_low();
    t_stretch_high();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule